// File: doc/BRIEF.md
# Single-Register Load/Store Transfer Unit

This unit carries out one single-register memory transfer of a 32-bit RISC core. A one-cycle `start` pulse hands it a 32-bit instruction word. The unit decodes the word and reads three operands from the register file through three read ports. These operands are the base, the offset register and the store source. From them it forms an offset, which is either a 12-bit immediate or a barrel-shifted register. It adds that offset to the base or subtracts it from the base. It then chooses the pre-indexed or the post-indexed address for the access.

The unit issues exactly one memory request with byte strobes and holds it until the memory accepts it. For a load, it waits for the read response and aligns the returned word to the destination register. The load result and the updated base go back to the register file through two write ports in the same cycle. A one-cycle `done` pulse follows in the next cycle. Store data is placed on the byte lanes before the request leaves the unit.

Top module: `lsu_xfer_unit`

## Requirements
- R1: Instruction fields: base index in bits [19:16], transfer data index in bits [15:12], offset-source select in bit 25, pre-index in bit 24, add in bit 23, byte size in bit 22, writeback in bit 21, load in bit 20.
- R2: When bit 25 is 1, the offset is bits [11:0] zero-extended to 32 bits.
- R3: When bit 25 is 0, the offset is the register indexed by bits [3:0], shifted by the amount in bits [11:7]. The shift kind is taken from bits [6:5]: 00 shifts left, 01 shifts right logically, 10 shifts right arithmetically, 11 rotates right. An amount of 0 leaves the value unchanged.
- R4: With bit 23 at 1 the modified base is base plus offset; with bit 23 at 0 it is base minus offset.
- R5: With bit 24 at 1 the access uses the modified base; with bit 24 at 0 it uses the unmodified base.
- R6: A word store drives the address with bits [1:0] cleared, all four strobes (4'b1111) and the full source register as write data.
- R7: A byte store drives the unaligned address and copies source bits [7:0] onto all four lanes. Its strobe is the one-hot value 1 << addr[1:0].
- R8: A byte load writes the byte at lane addr[1:0] of the read word to the destination register, zero-extended. Its request carries the same one-hot strobe.
- R9: A word load requests the aligned address with all strobes. It writes the read word rotated right by 8*addr[1:0] bits.
- R10: The modified base is written to the base register when bit 24 is 0, or when bits 24 and 21 are both 1. In every other case no base write occurs.
- R11: When a load's destination index equals its base index, only the loaded value is written to that register and the base write is dropped.
- R12: The request stays valid, with address, strobes and data unchanged, until the cycle in which it is accepted. No request is valid after reset.
- R13: `done` is high for exactly one cycle, in the cycle right after the register writes. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer with `instr`, taken when idle |
| instr | input | 32 | Transfer instruction word |
| rf_base_idx | output | 4 | Read port A index (base) |
| rf_off_idx | output | 4 | Read port B index (offset register) |
| rf_src_idx | output | 4 | Read port C index (store source) |
| rf_base_val | input | 32 | Read port A data |
| rf_off_val | input | 32 | Read port B data |
| rf_src_val | input | 32 | Read port C data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_be | output | 4 | Byte strobes |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (aligned word) |
| wb_ld_en | output | 1 | Load result write enable |
| wb_ld_idx | output | 4 | Load result register index |
| wb_ld_data | output | 32 | Load result value |
| wb_base_en | output | 1 | Base writeback enable |
| wb_base_idx | output | 4 | Base writeback register index |
| wb_base_data | output | 32 | Updated base value |
| done | output | 1 | Transfer finished pulse |

## Verification
Two functions can land in the same write cycle: the load result write and the base writeback. A load that also updates its base drives both ports at once. When the destination and the base are the same register, the two writes collide. The bench exercises this with post-indexed and pre-indexed writeback loads whose destination index equals the base index. The scoreboard then expects one load write and no base write for such cases, and a pair of writes on distinct indices everywhere else. Any extra or missing write item is counted as a failure.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int REG_IDX_W = 4;
  localparam int IMM_W     = 12;
  localparam int SHAMT_W   = 5;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_REQ,
    ST_WAIT,
    ST_WB,
    ST_FIN
  } xfer_state_e;

  typedef struct packed {
    logic                 imm_sel;
    logic                 pre;
    logic                 up;
    logic                 byte_sz;
    logic                 wback;
    logic                 load;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rm;
    logic [SHAMT_W-1:0]   sh_amt;
    shift_kind_e          sh_kind;
    logic [IMM_W-1:0]     imm;
  } xfer_dec_t;

  function automatic xfer_dec_t decode_xfer(input logic [31:0] w);
    xfer_dec_t d;
    d.imm_sel = w[25];
    d.pre     = w[24];
    d.up      = w[23];
    d.byte_sz = w[22];
    d.wback   = w[21];
    d.load    = w[20];
    d.rn      = w[19:16];
    d.rd      = w[15:12];
    d.rm      = w[3:0];
    d.sh_amt  = w[11:7];
    d.sh_kind = shift_kind_e'(w[6:5]);
    d.imm     = w[11:0];
    return d;
  endfunction

endpackage

// File: rtl/lsu_offset_shift.sv
module lsu_offset_shift
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               imm_sel,
  input  logic [IMM_W-1:0]   imm,
  input  logic [DATA_W-1:0]  reg_val,
  input  logic [SHAMT_W-1:0] amt,
  input  shift_kind_e        kind,
  output logic [DATA_W-1:0]  offset
);

  logic [DATA_W-1:0] shifted;

  always_comb begin
    unique case (kind)
      SH_LSL:  shifted = reg_val << amt;
      SH_LSR:  shifted = reg_val >> amt;
      SH_ASR:  shifted = $unsigned($signed(reg_val) >>> amt);
      default: shifted = DATA_W'({reg_val, reg_val} >> amt);
    endcase
  end

  assign offset = imm_sel ? DATA_W'(imm) : shifted;

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  input  logic              up,
  input  logic              pre,
  output logic [DATA_W-1:0] new_base,
  output logic [DATA_W-1:0] access_addr
);

  assign new_base    = up ? (base + offset) : (base - offset);
  assign access_addr = pre ? new_base : base;

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] lane,
  input  logic              byte_sz,
  input  logic [DATA_W-1:0] store_val,
  input  logic [DATA_W-1:0] load_raw,
  output logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  strobes,
  output logic [DATA_W-1:0] load_val
);

  logic [DATA_W-1:0] byte_copies;
  logic [LANE_W+2:0] bit_sh;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byte_copies[g*8 +: 8] = store_val[7:0];
  end

  assign bit_sh     = {1'b0, lane, 3'b000};
  assign store_data = byte_sz ? byte_copies : store_val;
  assign strobes    = byte_sz ? (LANES'(1) << lane) : {LANES{1'b1}};

  always_comb begin
    if (byte_sz)
      load_val = {{(DATA_W-8){1'b0}}, 8'(load_raw >> bit_sh)};
    else
      load_val = DATA_W'({load_raw, load_raw} >> bit_sh);
  end

endmodule

// File: rtl/lsu_xfer_unit.sv
module lsu_xfer_unit
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [31:0]          instr,
  output logic [REG_IDX_W-1:0] rf_base_idx,
  output logic [REG_IDX_W-1:0] rf_off_idx,
  output logic [REG_IDX_W-1:0] rf_src_idx,
  input  logic [DATA_W-1:0]    rf_base_val,
  input  logic [DATA_W-1:0]    rf_off_val,
  input  logic [DATA_W-1:0]    rf_src_val,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic                 mem_we,
  output logic [DATA_W-1:0]    mem_addr,
  output logic [LANES-1:0]     mem_be,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic                 mem_rvalid,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 wb_ld_en,
  output logic [REG_IDX_W-1:0] wb_ld_idx,
  output logic [DATA_W-1:0]    wb_ld_data,
  output logic                 wb_base_en,
  output logic [REG_IDX_W-1:0] wb_base_idx,
  output logic [DATA_W-1:0]    wb_base_data,
  output logic                 done
);

  xfer_state_e       st;
  xfer_dec_t         dec_q;
  logic [DATA_W-1:0] offset, new_base, acc_addr, nbase_q;
  logic [DATA_W-1:0] st_data, ld_val;
  logic [LANES-1:0]  strobe;
  logic [LANE_W-1:0] lane_q, lane_sel;
  logic              base_wr;

  assign rf_base_idx = dec_q.rn;
  assign rf_off_idx  = dec_q.rm;
  assign rf_src_idx  = dec_q.rd;
  assign wb_ld_idx   = dec_q.rd;
  assign wb_base_idx = dec_q.rn;

  lsu_offset_shift #(.DATA_W(DATA_W)) u_shift (
    .imm_sel (dec_q.imm_sel),
    .imm     (dec_q.imm),
    .reg_val (rf_off_val),
    .amt     (dec_q.sh_amt),
    .kind    (dec_q.sh_kind),
    .offset  (offset)
  );

  lsu_addr_gen #(.DATA_W(DATA_W)) u_addr (
    .base        (rf_base_val),
    .offset      (offset),
    .up          (dec_q.up),
    .pre         (dec_q.pre),
    .new_base    (new_base),
    .access_addr (acc_addr)
  );

  assign lane_sel = (st == ST_CALC) ? acc_addr[LANE_W-1:0] : lane_q;

  lsu_lane_align #(.DATA_W(DATA_W)) u_align (
    .lane       (lane_sel),
    .byte_sz    (dec_q.byte_sz),
    .store_val  (rf_src_val),
    .load_raw   (mem_rdata),
    .store_data (st_data),
    .strobes    (strobe),
    .load_val   (ld_val)
  );

  // base update: always when post-indexed, on request when pre-indexed;
  // a load into the same register takes precedence
  assign base_wr = (!dec_q.pre || dec_q.wback) &&
                   !(dec_q.load && (dec_q.rd == dec_q.rn));

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      dec_q         <= '0;
      nbase_q       <= '0;
      lane_q        <= '0;
      mem_req_valid <= 1'b0;
      mem_we        <= 1'b0;
      mem_addr      <= '0;
      mem_be        <= '0;
      mem_wdata     <= '0;
      wb_ld_en      <= 1'b0;
      wb_ld_data    <= '0;
      wb_base_en    <= 1'b0;
      wb_base_data  <= '0;
      done          <= 1'b0;
    end else begin
      done       <= 1'b0;
      wb_ld_en   <= 1'b0;
      wb_base_en <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            dec_q <= decode_xfer(instr);
            st    <= ST_CALC;
          end
        end
        ST_CALC: begin
          mem_addr      <= dec_q.byte_sz ? acc_addr
                                         : {acc_addr[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
          mem_be        <= strobe;
          mem_wdata     <= st_data;
          mem_we        <= !dec_q.load;
          mem_req_valid <= 1'b1;
          nbase_q       <= new_base;
          lane_q        <= acc_addr[LANE_W-1:0];
          st            <= ST_REQ;
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            if (dec_q.load) begin
              st <= ST_WAIT;
            end else begin
              wb_base_en   <= base_wr;
              wb_base_data <= nbase_q;
              st           <= ST_WB;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            wb_ld_en     <= 1'b1;
            wb_ld_data   <= ld_val;
            wb_base_en   <= base_wr;
            wb_base_data <= nbase_q;
            st           <= ST_WB;
          end
        end
        ST_WB: begin
          done <= 1'b1;
          st   <= ST_FIN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lsu_xfer_unit_chk.sv
module lsu_xfer_unit_chk #(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [DATA_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              wb_ld_en,
  input logic [3:0]        wb_ld_idx,
  input logic              wb_base_en,
  input logic [3:0]        wb_base_idx,
  input logic              done
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) &&
                                        $stable(mem_be) && $stable(mem_wdata));

  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && (mem_be == {LANES{1'b1}}) |-> mem_addr[LANE_W-1:0] == '0);

  // R7
  strobe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> ($countones(mem_be) == 1) || (mem_be == {LANES{1'b1}}));

  // R8
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && ($countones(mem_be) == 1) |->
      mem_be == (LANES'(1) << mem_addr[LANE_W-1:0]));

  // R11
  wr_clash_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ld_en && wb_base_en |-> wb_ld_idx != wb_base_idx);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R13
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req_valid && !wb_ld_en && !wb_base_en);

endmodule

bind lsu_xfer_unit lsu_xfer_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .mem_be        (mem_be),
  .mem_wdata     (mem_wdata),
  .wb_ld_en      (wb_ld_en),
  .wb_ld_idx     (wb_ld_idx),
  .wb_base_en    (wb_base_en),
  .wb_base_idx   (wb_base_idx),
  .done          (done)
);

// File: tb/lsu_xfer_unit_bench.sv
module lsu_xfer_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  rf_base_idx, rf_off_idx, rf_src_idx;
  logic [31:0] rf_base_val, rf_off_val, rf_src_val;
  logic        mem_req_valid, mem_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        wb_ld_en, wb_base_en, done;
  logic [3:0]  wb_ld_idx, wb_base_idx;
  logic [31:0] wb_ld_data, wb_base_data;

  always #2 clk = ~clk;

  logic [31:0] regs [16];
  logic [31:0] mem  [64];

  assign rf_base_val = regs[rf_base_idx];
  assign rf_off_val  = regs[rf_off_idx];
  assign rf_src_val  = regs[rf_src_idx];

  lsu_xfer_unit u_lsu_xfer_unit (.*);

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  be;
    logic        we;
    logic [31:0] wdata;
  } req_t;
  typedef struct {
    logic [3:0]  idx;
    logic [31:0] data;
  } wr_t;

  req_t  exp_req[$];
  wr_t   exp_ld[$];
  wr_t   exp_bs[$];
  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R12/R13";
  bit    op_has_wr, done_seen, wr_prev, done_prev, rd_pend, finished;
  logic [5:0] rd_idx;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    rotr = (n == 0) ? v : ((v >> n) | (v << (32 - n)));
  endfunction

  function automatic logic [31:0] enc(input bit i, p, u, b, w, l,
                                      input logic [3:0] rn, rd,
                                      input logic [11:0] op);
    enc = {4'hE, 2'b01, i, p, u, b, w, l, rn, rd, op};
  endfunction

  function automatic logic [11:0] roff(input logic [4:0] amt,
                                       input logic [1:0] kind,
                                       input logic [3:0] rm);
    roff = {amt, kind, 1'b0, rm};
  endfunction

  // driver: build expectations from the requirements, then launch
  task automatic run_op(input logic [31:0] ins, input string tag);
    logic [3:0]  rn, rd, rm;
    logic [31:0] base, off, nb, acc, word, v;
    logic [4:0]  amt;
    logic [1:0]  ln;
    req_t        rq;
    wr_t         wr;
    bit          is_load, is_byte;
    int          t;
    rn = ins[19:16]; rd = ins[15:12]; rm = ins[3:0];
    amt = ins[11:7]; is_load = ins[20]; is_byte = ins[22];
    base = regs[rn];
    if (ins[25]) off = {20'd0, ins[11:0]};
    else begin
      v = regs[rm];
      case (ins[6:5])
        2'b00: off = v << amt;
        2'b01: off = v >> amt;
        2'b10: off = $unsigned($signed(v) >>> amt);
        default: off = rotr(v, int'(amt));
      endcase
    end
    nb  = ins[23] ? base + off : base - off;
    acc = ins[24] ? nb : base;
    ln  = acc[1:0];
    rq.addr  = is_byte ? acc : {acc[31:2], 2'b00};
    rq.be    = is_byte ? (4'b0001 << ln) : 4'b1111;
    rq.we    = !is_load;
    rq.wdata = is_byte ? {4{regs[rd][7:0]}} : regs[rd];
    exp_req.push_back(rq);
    op_has_wr = 1'b0;
    if (is_load) begin
      word    = mem[acc[7:2]];
      wr.idx  = rd;
      wr.data = is_byte ? ((word >> (8 * ln)) & 32'hFF) : rotr(word, 8 * ln);
      exp_ld.push_back(wr);
      op_has_wr = 1'b1;
    end
    if ((!ins[24] || ins[21]) && !(is_load && rd == rn)) begin
      wr.idx  = rn;
      wr.data = nb;
      exp_bs.push_back(wr);
      op_has_wr = 1'b1;
    end
    cur_tag = tag;
    done_seen = 1'b0;
    @(negedge clk);
    instr = ins;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done_seen && t < 60) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    check(done_seen, "R13", "done seen", 32'(done_seen), 32'd1);
    check(exp_req.size() == 0 && exp_ld.size() == 0 && exp_bs.size() == 0,
          tag, "items left", 32'(exp_req.size() + exp_ld.size() + exp_bs.size()), 32'd0);
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    if (!rst) begin
      mem_rvalid = rd_pend;
      if (rd_pend) mem_rdata = mem[rd_idx];
      rd_pend = 1'b0;
      mem_req_ready = 1'($urandom_range(0, 1));
      if (mem_req_valid && mem_req_ready) begin
        if (exp_req.size() == 0) begin
          check(1'b0, cur_tag, "unexpected request", mem_addr, 32'd0);
        end else begin
          req_t e;
          e = exp_req.pop_front();
          check(mem_addr == e.addr, cur_tag, "address", mem_addr, e.addr);
          check(mem_be == e.be, cur_tag, "strobes", 32'(mem_be), 32'(e.be));
          check(mem_we == e.we, cur_tag, "direction", 32'(mem_we), 32'(e.we));
          if (e.we) begin
            check(mem_wdata == e.wdata, cur_tag, "write data", mem_wdata, e.wdata);
            for (int k = 0; k < 4; k++)
              if (mem_be[k]) mem[mem_addr[7:2]][k*8 +: 8] = mem_wdata[k*8 +: 8];
          end else begin
            rd_pend = 1'b1;
            rd_idx  = mem_addr[7:2];
          end
        end
      end
      if (wb_ld_en) begin
        if (exp_ld.size() == 0) check(1'b0, cur_tag, "unexpected load write", wb_ld_data, 32'd0);
        else begin
          wr_t e;
          e = exp_ld.pop_front();
          check(wb_ld_idx == e.idx, cur_tag, "load index", 32'(wb_ld_idx), 32'(e.idx));
          check(wb_ld_data == e.data, cur_tag, "load data", wb_ld_data, e.data);
        end
      end
      if (wb_base_en) begin
        if (exp_bs.size() == 0) check(1'b0, cur_tag, "unexpected base write", wb_base_data, 32'd0);
        else begin
          wr_t e;
          e = exp_bs.pop_front();
          check(wb_base_idx == e.idx, cur_tag, "base index", 32'(wb_base_idx), 32'(e.idx));
          check(wb_base_data == e.data, cur_tag, "base data", wb_base_data, e.data);
        end
      end
      if (wb_ld_en)   regs[wb_ld_idx]   = wb_ld_data;
      if (wb_base_en) regs[wb_base_idx] = wb_base_data;
      if (done) begin
        done_seen = 1'b1;
        // R13: done follows the write cycle and lasts one cycle
        if (op_has_wr) check(wr_prev, "R13", "done after writes", 32'(wr_prev), 32'd1);
        check(!done_prev, "R13", "done width", 32'(done_prev), 32'd0);
      end
      wr_prev   = wb_ld_en || wb_base_en;
      done_prev = done;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", "run timed out", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h100 * i;
    regs[1]  = 32'h40;   regs[2] = 32'h80;   regs[3] = 32'h3;
    regs[4]  = 32'hFFFF_FF00; regs[5] = 32'h1234_5678; regs[6] = 32'h8;
    regs[13] = 32'h0000_0400;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA1B2_C3D4 ^ (32'h0101_0101 * i);
    repeat (3) @(negedge clk);
    // R12 R13: quiet outputs after reset
    check(!mem_req_valid && !done && !wb_ld_en && !wb_base_en, "R12/R13",
          "reset outputs", {28'd0, mem_req_valid, done, wb_ld_en, wb_base_en}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    run_op(enc(1,1,1,0,0,1, 4'd1, 4'd7, 12'd4),  "R1/R2/R5/R9");
    run_op(enc(1,1,1,0,0,1, 4'd1, 4'd7, 12'd5),  "R9");
    run_op(enc(1,1,1,0,0,1, 4'd1, 4'd8, 12'd7),  "R9");
    run_op(enc(1,1,1,1,0,1, 4'd1, 4'd9, 12'd6),  "R8/R10");
    run_op(enc(1,1,1,0,0,0, 4'd2, 4'd5, 12'd2),  "R6");
    run_op(enc(1,1,1,1,0,0, 4'd2, 4'd5, 12'd7),  "R7");
    run_op(enc(1,1,1,0,0,1, 4'd2, 4'd10, 12'd4), "R6/R9");
    run_op(enc(0,1,1,0,0,1, 4'd1, 4'd10, roff(5'd2, 2'b00, 4'd3)), "R3");
    run_op(enc(0,1,0,0,0,1, 4'd2, 4'd10, roff(5'd1, 2'b01, 4'd6)), "R3/R4");
    run_op(enc(0,1,1,0,0,1, 4'd1, 4'd11, roff(5'd4, 2'b10, 4'd4)), "R3");
    run_op(enc(0,1,1,0,0,1, 4'd1, 4'd12, roff(5'd8, 2'b11, 4'd13)), "R3");
    run_op(enc(0,1,1,1,0,1, 4'd1, 4'd12, roff(5'd0, 2'b01, 4'd3)), "R3");
    run_op(enc(1,0,1,0,0,1, 4'd1, 4'd7, 12'd8),  "R5/R10");
    run_op(enc(1,1,0,0,1,0, 4'd2, 4'd5, 12'd4),  "R4/R10");
    run_op(enc(1,0,0,1,0,0, 4'd2, 4'd5, 12'd1),  "R7/R10");
    run_op(enc(1,0,1,0,0,1, 4'd1, 4'd1, 12'd4),  "R11");
    run_op(enc(1,1,1,1,1,1, 4'd2, 4'd2, 12'd3),  "R11");
    run_op(enc(1,1,1,0,1,1, 4'd6, 4'd14, 12'd0), "R10");
    finish_run();
  end

endmodule